// File: doc/BRIEF.md
# Byte-Wide Accumulator Datapath with Split Address Register

This block is the register datapath of a small 8-bit processor. The block makes no sequencing decisions. Every cycle a microcode sequencer outside the block presents a set of decoded control fields, and the datapath carries out exactly what those fields ask for. The datapath holds:

- three general registers A, B and C;
- a byte-wide memory data register (MDR) that captures the memory read byte;
- a 16-bit program counter;
- an output latch;
- a 16-bit memory address register (MAR) built from two byte halves.

All byte movement goes over one shared internal bus. In any cycle at most one source should drive that bus, and every register that is told to load takes the bus value at the next rising clock edge.

The memory address leaves the block through a two-way selector that picks the program counter or the MAR. An arithmetic unit always works on A and B and can place its result on the bus. A RAM write presents the bus byte as write data, together with a write strobe, in the same cycle the write is requested. A 16-bit address for a store is built in two separate bus steps, one for each MAR half. The program counter can be preset from that assembled address.

Top module: `acc_datapath`

## Requirements
- R1: `rst_n` is a synchronous, active-low reset. After reset, A, B, C, the MDR, the output latch, the MAR and the program counter are all zero. While `rst_n` is low, `wr_en` stays low.
- R2: The bus sources are the register output-enable codes, `mdr_drive`, an active ALU code and `out_read`. When none of them is active, the bus value is zero.
- R3: The `reg_op` codes 3'b001, 3'b010 and 3'b011 load the bus into A, B and C respectively at the next edge.
- R4: `reg_op` 3'b111 captures `rd_data` into the MDR. `mdr_drive` places the MDR on the bus.
- R5: The `alu_op` codes 1 to 6 place A, A+B, A−B, A&B, A|B and A^B on the bus. Sums and differences are 8 bits and wrap. Codes 0 and 7 place nothing on the bus.
- R6: `mem_addr` equals the program counter when `addr_sel` is 1 and equals the MAR when it is 0.
- R7: `mem_op` 3'b100 loads the bus into the MAR low byte and 3'b110 loads it into the high byte; in both cases the other byte is unchanged. `mem_op` 3'b101 loads the whole MAR from the program counter.
- R8: `pc_op` 3'b001 clears the program counter, 3'b010 presets it from the MAR, 3'b110 increments it and 3'b111 decrements it, with 16-bit wrap. The codes 0, 3, 4 and 5 leave it unchanged.
- R9: `mem_op` 3'b011 raises `wr_en` in that same cycle, with `wr_data` equal to the bus value. No other `mem_op` code raises `wr_en`.
- R10: `out_load` loads the bus into the output latch, and `out_value` always shows the latch. `out_read` places the latch on the bus.
- R11: When several sources are active in the same cycle, the bus takes the first one in this order: the register output-enable codes (3'b100 = A, 3'b101 = B, 3'b110 = C), then the MDR, then the ALU, then the output latch.
- R12: Every load that happens at an edge uses the register values from before that edge. This applies to a PC preset together with a MAR load, a full MAR load together with a PC change, and an ALU result written back into A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_op | input | 3 | Register load / output-enable / MDR capture code |
| mem_op | input | 3 | Memory and MAR code |
| pc_op | input | 3 | Program counter code |
| alu_op | input | 3 | ALU function code, 0 = off |
| addr_sel | input | 1 | 1 = program counter drives the address, 0 = MAR |
| mdr_drive | input | 1 | MDR drives the bus |
| out_load | input | 1 | Output latch loads from the bus |
| out_read | input | 1 | Output latch drives the bus |
| rd_data | input | 8 | Byte read from memory |
| mem_addr | output | 16 | Memory address |
| wr_data | output | 8 | RAM write data (bus value) |
| wr_en | output | 1 | RAM write strobe |
| out_value | output | 8 | Output latch contents |

## Verification
The functions most likely to coincide are a register change at a clock edge and a read of that same register's old value in the same cycle. Examples are a PC increment while `addr_sel` shows the PC, a PC preset in the cycle a MAR half loads, and an ALU sum written back into A. The bench provokes these pairings in two ways: with directed sequences, and with random cycles in which all control fields change independently. It judges the result by comparing `mem_addr`, `wr_data` and `out_value` with a model. That model computes every next state only from values held before the edge.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

  localparam int unsigned NUM_GP = 3;

  typedef enum logic [2:0] {
    REG_NOP    = 3'd0,
    REG_LD_A   = 3'd1,
    REG_LD_B   = 3'd2,
    REG_LD_C   = 3'd3,
    REG_OE_A   = 3'd4,
    REG_OE_B   = 3'd5,
    REG_OE_C   = 3'd6,
    REG_LD_MDR = 3'd7
  } reg_op_e;

  typedef enum logic [2:0] {
    MEM_NOP      = 3'd0,
    MEM_ROM_RD   = 3'd1,
    MEM_RAM_RD   = 3'd2,
    MEM_RAM_WR   = 3'd3,
    MEM_MAR_LO   = 3'd4,
    MEM_MAR_FULL = 3'd5,
    MEM_MAR_HI   = 3'd6,
    MEM_RSVD     = 3'd7
  } mem_op_e;

  typedef enum logic [2:0] {
    PC_NOP    = 3'd0,
    PC_CLR    = 3'd1,
    PC_PRESET = 3'd2,
    PC_RSV3   = 3'd3,
    PC_RSV4   = 3'd4,
    PC_STOP   = 3'd5,
    PC_INC    = 3'd6,
    PC_DEC    = 3'd7
  } pc_op_e;

  typedef enum logic [2:0] {
    ALU_OFF  = 3'd0,
    ALU_PASS = 3'd1,
    ALU_ADD  = 3'd2,
    ALU_SUB  = 3'd3,
    ALU_AND  = 3'd4,
    ALU_OR   = 3'd5,
    ALU_XOR  = 3'd6,
    ALU_RSVD = 3'd7
  } alu_op_e;

endpackage

// File: rtl/acc_alu.sv
module acc_alu import acc_dp_pkg::*; #(
  parameter int unsigned DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic              drives
);

  // returns {drive flag, value}
  function automatic logic [DATA_W:0] alu_fn(alu_op_e f, logic [DATA_W-1:0] x,
                                             logic [DATA_W-1:0] y);
    case (f)
      ALU_PASS: return {1'b1, x};
      ALU_ADD:  return {1'b1, DATA_W'(x + y)};
      ALU_SUB:  return {1'b1, DATA_W'(x - y)};
      ALU_AND:  return {1'b1, x & y};
      ALU_OR:   return {1'b1, x | y};
      ALU_XOR:  return {1'b1, x ^ y};
      default:  return '0;
    endcase
  endfunction

  assign {drives, result} = alu_fn(op, opnd_a, opnd_b);

endmodule

// File: rtl/acc_regs.sv
module acc_regs import acc_dp_pkg::*; #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  reg_op_e                        reg_op,
  input  logic                           out_load,
  input  logic [DATA_W-1:0]              bus,
  input  logic [DATA_W-1:0]              rd_data,
  output logic [NUM_GP-1:0][DATA_W-1:0]  gp_q,
  output logic [DATA_W-1:0]              mdr_q,
  output logic [DATA_W-1:0]              outl_q
);

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    localparam logic [2:0] LD_CODE = 3'(32'(REG_LD_A) + g);
    always_ff @(posedge clk) begin
      if (!rst_n)                             gp_q[g] <= '0;
      else if (reg_op == reg_op_e'(LD_CODE))  gp_q[g] <= bus;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     mdr_q <= '0;
    else if (reg_op == REG_LD_MDR)  mdr_q <= rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        outl_q <= '0;
    else if (out_load) outl_q <= bus;
  end

endmodule

// File: rtl/acc_addr.sv
module acc_addr import acc_dp_pkg::*; #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  mem_op_e               mem_op,
  input  pc_op_e                pc_op,
  input  logic                  addr_sel,
  input  logic [DATA_W-1:0]     bus,
  output logic [2*DATA_W-1:0]   pc_q,
  output logic [2*DATA_W-1:0]   mar_q,
  output logic [2*DATA_W-1:0]   mem_addr
);

  localparam int unsigned ADDR_W = 2 * DATA_W;

  logic [1:0][DATA_W-1:0] mar_half;

  function automatic logic [ADDR_W-1:0] pc_step(pc_op_e f, logic [ADDR_W-1:0] cur,
                                                logic [ADDR_W-1:0] mar);
    case (f)
      PC_CLR:    return '0;
      PC_PRESET: return mar;
      PC_INC:    return ADDR_W'(cur + 1'b1);
      PC_DEC:    return ADDR_W'(cur - 1'b1);
      default:   return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_step(pc_op, pc_q, mar_q);
  end

  // low half at index 0, high half at index 1
  for (genvar h = 0; h < 2; h++) begin : g_mar
    localparam mem_op_e HALF_CODE = (h == 0) ? MEM_MAR_LO : MEM_MAR_HI;
    always_ff @(posedge clk) begin
      if (!rst_n)                       mar_half[h] <= '0;
      else if (mem_op == MEM_MAR_FULL)  mar_half[h] <= pc_q[h*DATA_W +: DATA_W];
      else if (mem_op == HALF_CODE)     mar_half[h] <= bus;
    end
  end

  assign mar_q    = mar_half;
  assign mem_addr = addr_sel ? pc_q : mar_q;

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath import acc_dp_pkg::*; #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             reg_op,
  input  logic [2:0]             mem_op,
  input  logic [2:0]             pc_op,
  input  logic [2:0]             alu_op,
  input  logic                   addr_sel,
  input  logic                   mdr_drive,
  input  logic                   out_load,
  input  logic                   out_read,
  input  logic [DATA_W-1:0]      rd_data,
  output logic [2*DATA_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]      wr_data,
  output logic                   wr_en,
  output logic [DATA_W-1:0]      out_value
);

  localparam int unsigned ADDR_W = 2 * DATA_W;

  logic [NUM_GP-1:0][DATA_W-1:0] gp_q;
  logic [DATA_W-1:0]             mdr_q, outl_q, alu_y, bus_w;
  logic                          alu_drv;
  logic [ADDR_W-1:0]             pc_q, mar_q;

  // named source events
  logic src_gp, src_mdr, src_alu, src_out, bus_idle;
  logic [1:0] gp_sel;

  assign src_gp   = reg_op[2] && (reg_op != 3'(REG_LD_MDR));
  assign gp_sel   = reg_op[1:0];
  assign src_mdr  = mdr_drive;
  assign src_alu  = alu_drv;
  assign src_out  = out_read;
  assign bus_idle = !(src_gp || src_mdr || src_alu || src_out);

  always_comb begin
    if (src_gp)       bus_w = gp_q[gp_sel];
    else if (src_mdr) bus_w = mdr_q;
    else if (src_alu) bus_w = alu_y;
    else if (src_out) bus_w = outl_q;
    else              bus_w = '0;
  end

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (alu_op_e'(alu_op)),
    .opnd_a (gp_q[0]),
    .opnd_b (gp_q[1]),
    .result (alu_y),
    .drives (alu_drv)
  );

  acc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_op   (reg_op_e'(reg_op)),
    .out_load (out_load),
    .bus      (bus_w),
    .rd_data  (rd_data),
    .gp_q     (gp_q),
    .mdr_q    (mdr_q),
    .outl_q   (outl_q)
  );

  acc_addr #(.DATA_W(DATA_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_op   (mem_op_e'(mem_op)),
    .pc_op    (pc_op_e'(pc_op)),
    .addr_sel (addr_sel),
    .bus      (bus_w),
    .pc_q     (pc_q),
    .mar_q    (mar_q),
    .mem_addr (mem_addr)
  );

  assign wr_en     = rst_n && (mem_op == 3'(MEM_RAM_WR));
  assign wr_data   = bus_w;
  assign out_value = outl_q;

endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk import acc_dp_pkg::*; #(
  parameter int unsigned DATA_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            mem_op,
  input logic [2:0]            pc_op,
  input logic                  addr_sel,
  input logic [2*DATA_W-1:0]   mem_addr,
  input logic [2*DATA_W-1:0]   pc_q,
  input logic [2*DATA_W-1:0]   mar_q,
  input logic [DATA_W-1:0]     bus_w,
  input logic                  bus_idle
);

  // R2
  bus_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> bus_w == '0);

  // R6
  addr_pc_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_sel |-> mem_addr == pc_q);

  // R8
  pc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_op == 3'(PC_INC) |=> pc_q == $past(pc_q) + 1'b1);

  // R8
  pc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_op == 3'(PC_CLR) |=> pc_q == '0);

  // R7
  mar_lo_keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_op == 3'(MEM_MAR_LO) |=>
      (mar_q[DATA_W-1:0] == $past(bus_w)) &&
      (mar_q[2*DATA_W-1:DATA_W] == $past(mar_q[2*DATA_W-1:DATA_W])));

  // R12
  pc_preset_old_mar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_op == 3'(PC_PRESET) |=> pc_q == $past(mar_q));

endmodule

bind acc_datapath acc_datapath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_op   (mem_op),
  .pc_op    (pc_op),
  .addr_sel (addr_sel),
  .mem_addr (mem_addr),
  .pc_q     (pc_q),
  .mar_q    (mar_q),
  .bus_w    (bus_w),
  .bus_idle (bus_idle)
);

// File: tb/acc_datapath_test.sv
`timescale 1ns/1ps
module acc_datapath_test;
  import acc_dp_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_op = '0, mem_op = '0, pc_op = '0, alu_op = '0;
  logic addr_sel = 1'b0, mdr_drive = 1'b0, out_load = 1'b0, out_read = 1'b0;
  logic [7:0] rd_data = '0;
  logic [15:0] mem_addr;
  logic [7:0] wr_data, out_value;
  logic wr_en;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0]  m_a = '0, m_b = '0, m_c = '0, m_mdr = '0, m_out = '0;
  logic [15:0] m_pc = '0, m_mar = '0;

  always #2.5 clk = ~clk;

  acc_datapath uut (
    .clk(clk), .rst_n(rst_n), .reg_op(reg_op), .mem_op(mem_op), .pc_op(pc_op),
    .alu_op(alu_op), .addr_sel(addr_sel), .mdr_drive(mdr_drive),
    .out_load(out_load), .out_read(out_read), .rd_data(rd_data),
    .mem_addr(mem_addr), .wr_data(wr_data), .wr_en(wr_en), .out_value(out_value)
  );

  function automatic logic [8:0] alu_ref(logic [2:0] f, logic [7:0] x, logic [7:0] y);
    logic [7:0] s = x + y;
    logic [7:0] d = x - y;
    if (f == 3'd1) return {1'b1, x};
    if (f == 3'd2) return {1'b1, s};
    if (f == 3'd3) return {1'b1, d};
    if (f == 3'd4) return {1'b1, x & y};
    if (f == 3'd5) return {1'b1, x | y};
    if (f == 3'd6) return {1'b1, x ^ y};
    return 9'd0;
  endfunction

  function automatic logic [7:0] bus_ref();
    logic [8:0] al = alu_ref(alu_op, m_a, m_b);
    if (reg_op == 3'd4) return m_a;
    if (reg_op == 3'd5) return m_b;
    if (reg_op == 3'd6) return m_c;
    if (mdr_drive) return m_mdr;
    if (al[8]) return al[7:0];
    if (out_read) return m_out;
    return 8'd0;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set(logic [2:0] r, logic [2:0] m, logic [2:0] p, logic [2:0] a,
                     logic sel, logic md, logic ol, logic orr, logic [7:0] rd);
    reg_op = r; mem_op = m; pc_op = p; alu_op = a; addr_sel = sel;
    mdr_drive = md; out_load = ol; out_read = orr; rd_data = rd;
  endtask

  // compare outputs against model, then clock once and advance model
  task automatic step();
    logic [7:0] bv;
    logic [15:0] npc, nmar;
    #0.5;
    bv = bus_ref();
    chk("R6 mem_addr", mem_addr, addr_sel ? m_pc : m_mar);
    chk("R9 wr_en", {15'd0, wr_en}, {15'd0, rst_n && mem_op == 3'd3});
    if (wr_en) chk("R9 wr_data", {8'd0, wr_data}, {8'd0, bv});
    chk("R10 out_value", {8'd0, out_value}, {8'd0, m_out});
    npc = m_pc; nmar = m_mar;
    case (pc_op)
      3'd1: npc = 16'd0;
      3'd2: npc = m_mar;
      3'd6: npc = m_pc + 16'd1;
      3'd7: npc = m_pc - 16'd1;
      default: ;
    endcase
    if (mem_op == 3'd4) nmar[7:0] = bv;
    if (mem_op == 3'd6) nmar[15:8] = bv;
    if (mem_op == 3'd5) nmar = m_pc;
    @(posedge clk);
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_c = 0; m_mdr = 0; m_out = 0; m_pc = 0; m_mar = 0;
    end else begin
      if (reg_op == 3'd1) m_a = bv;
      if (reg_op == 3'd2) m_b = bv;
      if (reg_op == 3'd3) m_c = bv;
      if (reg_op == 3'd7) m_mdr = rd_data;
      if (out_load) m_out = bv;
      m_pc = npc; m_mar = nmar;
    end
    @(negedge clk);
  endtask

  task automatic idle(logic sel);
    set(3'd0, 3'd0, 3'd0, 3'd0, sel, 0, 0, 0, 8'h00); step();
  endtask

  task automatic load_reg(logic [2:0] ld, logic [7:0] v);
    set(3'd7, 3'd1, 3'd0, 3'd0, 0, 0, 0, 0, v); step();
    set(ld, 3'd0, 3'd0, 3'd0, 0, 1, 0, 0, 8'h00); step();
  endtask

  task automatic alu_to_out(logic [2:0] f);
    set(3'd0, 3'd0, 3'd0, f, 0, 0, 1, 0, 8'h00); step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // R1: reset state, write requested while reset held
    set(3'd0, 3'd3, 3'd6, 3'd2, 1, 0, 0, 0, 8'h55); step();
    set(3'd0, 3'd3, 3'd0, 3'd0, 0, 0, 0, 0, 8'h00); step();
    #0.5;
    chk("R1 wr_en low in reset", {15'd0, wr_en}, 16'd0);
    chk("R1 mar zero", mem_addr, 16'd0);
    addr_sel = 1; #0.5;
    chk("R1 pc zero", mem_addr, 16'd0);
    chk("R1 out latch zero", {8'd0, out_value}, 16'd0);
    rst_n = 1;
    idle(0);

    // R4 and R3: MDR capture and transfer into A, then A to latch
    load_reg(3'd1, 8'h0D);
    set(3'd4, 3'd0, 3'd0, 3'd0, 0, 0, 1, 0, 8'h00); step();
    chk("R3 A via MDR", {8'd0, out_value}, 16'h000D);
    load_reg(3'd3, 8'hC3);
    set(3'd6, 3'd0, 3'd0, 3'd0, 0, 0, 1, 0, 8'h00); step();
    chk("R4 C via MDR", {8'd0, out_value}, 16'h00C3);

    // R5: ALU functions with wrap
    load_reg(3'd1, 8'hF0); load_reg(3'd2, 8'h20);
    alu_to_out(3'd2); chk("R5 ADD wrap", {8'd0, out_value}, 16'h0010);
    load_reg(3'd1, 8'h05); load_reg(3'd2, 8'h07);
    alu_to_out(3'd3); chk("R5 SUB wrap", {8'd0, out_value}, 16'h00FE);
    load_reg(3'd1, 8'hCA); load_reg(3'd2, 8'h0F);
    alu_to_out(3'd4); chk("R5 AND", {8'd0, out_value}, 16'h000A);
    alu_to_out(3'd5); chk("R5 OR", {8'd0, out_value}, 16'h00CF);
    alu_to_out(3'd6); chk("R5 XOR", {8'd0, out_value}, 16'h00C5);
    alu_to_out(3'd1); chk("R5 PASS", {8'd0, out_value}, 16'h00CA);
    alu_to_out(3'd7); chk("R5 reserved drives nothing", {8'd0, out_value}, 16'h0000);
    // R2: no source at all
    alu_to_out(3'd1);
    set(3'd0, 3'd0, 3'd0, 3'd0, 0, 0, 1, 0, 8'h00); step();
    chk("R2 idle bus zero", {8'd0, out_value}, 16'h0000);

    // R12: ALU result written back into A in the same cycle (A=0xCA, B=0x0F)
    set(3'd1, 3'd0, 3'd0, 3'd2, 0, 0, 0, 0, 8'h00); step();
    set(3'd4, 3'd0, 3'd0, 3'd0, 0, 0, 1, 0, 8'h00); step();
    chk("R12 A plus B into A", {8'd0, out_value}, 16'h00D9);

    // R7 and R6: split MAR loads
    load_reg(3'd1, 8'h34);
    set(3'd4, 3'd4, 3'd0, 3'd0, 0, 0, 0, 0, 8'h00); step();
    load_reg(3'd1, 8'h12);
    set(3'd4, 3'd6, 3'd0, 3'd0, 0, 0, 0, 0, 8'h00); step();
    idle(0); chk("R7 MAR halves", mem_addr, 16'h1234);
    load_reg(3'd1, 8'h99);
    set(3'd4, 3'd4, 3'd0, 3'd0, 0, 0, 0, 0, 8'h00); step();
    idle(0); chk("R7 low load keeps high", mem_addr, 16'h1299);

    // R8: PC operations
    set(3'd0, 3'd0, 3'd1, 3'd0, 1, 0, 0, 0, 8'h00); step();
    for (int i = 0; i < 3; i++) begin set(3'd0, 3'd0, 3'd6, 3'd0, 1, 0, 0, 0, 8'h00); step(); end
    idle(1); chk("R8 increment", mem_addr, 16'h0003);
    for (int i = 0; i < 4; i++) begin set(3'd0, 3'd0, 3'd7, 3'd0, 1, 0, 0, 0, 8'h00); step(); end
    idle(1); chk("R8 decrement wrap", mem_addr, 16'hFFFF);
    for (int i = 3; i < 6; i++) begin set(3'd0, 3'd0, 3'(i), 3'd0, 1, 0, 0, 0, 8'h00); step(); end
    chk("R8 codes 3 4 5 hold", mem_addr, 16'hFFFF);
    // R12: preset from old MAR while MAR low byte changes (A=0x99 -> write 0x77)
    load_reg(3'd1, 8'h77);
    set(3'd4, 3'd4, 3'd2, 3'd0, 1, 0, 0, 0, 8'h00); step();
    idle(1); chk("R12 preset uses old MAR", mem_addr, 16'h1299);
    idle(0); chk("R7 MAR took new low", mem_addr, 16'h1277);
    // R12: full MAR load from PC while PC increments
    set(3'd0, 3'd5, 3'd6, 3'd0, 0, 0, 0, 0, 8'h00); step();
    idle(0); chk("R12 full MAR from old PC", mem_addr, 16'h1299);
    idle(1); chk("R8 PC after increment", mem_addr, 16'h129A);

    // R9: write strobe and data
    load_reg(3'd2, 8'h5A);
    set(3'd5, 3'd3, 3'd0, 3'd0, 0, 0, 0, 0, 8'h00); #0.5;
    chk("R9 wr_en high", {15'd0, wr_en}, 16'd1);
    chk("R9 wr_data is B", {8'd0, wr_data}, 16'h005A);
    step();
    #0.5; chk("R9 wr_en one cycle", {15'd0, wr_en}, 16'd1);
    set(3'd0, 3'd0, 3'd0, 3'd0, 0, 0, 0, 0, 8'h00); #0.5;
    chk("R9 wr_en drops", {15'd0, wr_en}, 16'd0);
    set(3'd5, 3'd1, 3'd0, 3'd0, 0, 0, 0, 0, 8'h00); #0.5;
    chk("R9 ROM read no write", {15'd0, wr_en}, 16'd0);
    set(3'd5, 3'd7, 3'd0, 3'd0, 0, 0, 0, 0, 8'h00); #0.5;
    chk("R9 reserved no write", {15'd0, wr_en}, 16'd0);
    step();

    // R11: priority among sources (A=0x77, B=0x5A, MDR=0x5A)
    load_reg(3'd3, 8'h3C);  // MDR=0x3C, C=0x3C
    set(3'd4, 3'd0, 3'd0, 3'd2, 0, 1, 1, 1, 8'h00); step();
    chk("R11 register beats others", {8'd0, out_value}, 16'h0077);
    set(3'd0, 3'd0, 3'd0, 3'd2, 0, 1, 1, 1, 8'h00); step();
    chk("R11 MDR beats ALU", {8'd0, out_value}, 16'h003C);
    set(3'd0, 3'd0, 3'd0, 3'd6, 0, 0, 1, 1, 8'h00); step();
    chk("R11 ALU beats latch", {8'd0, out_value}, 16'h002D);
    // R10: latch drives bus into a register
    set(3'd3, 3'd0, 3'd0, 3'd0, 0, 0, 0, 1, 8'h00); step();
    set(3'd6, 3'd3, 3'd0, 3'd0, 0, 0, 0, 0, 8'h00); #0.5;
    chk("R10 latch read into C", {8'd0, wr_data}, 16'h002D);
    step();

    // random cycles compared against the model (R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12)
    for (int k = 0; k < 4000; k++) begin
      set(3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), 1'($urandom),
          ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0, 8'($urandom));
      step();
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule